// File: doc/BRIEF.md
# Base Address Register Bank

This block holds the base address registers of one configuration target, up to six 32-bit slots at byte offsets 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24. A configuration decoder feeds it writes and reads. Each write carries a byte offset, a length code and data. Each slot has a power-of-two region size and a 4-bit type code, both fixed by parameters. A slot whose size parameter is zero is not implemented. The slot index is the offset minus 0x10, shifted right by two.

An aligned dword write to an implemented slot is taken by the bank. The bank stores the data with every bit below the region size cleared and the type code ORed in. A value other than all-ones or all-zeros also relocates the region. In that case the bank emits a one-cycle remap event that carries the slot index, the new base and the previous base, and it sets the matching enable bit of the command register. Every other write is forwarded unchanged to the generic configuration store. A read of an implemented slot returns the stored encoded value, with the byte lane and length applied.

Top module: `bar_bank`

## Requirements
- R1: After reset every slot reads back as its type code alone. The bank holds no mapping, both command enables are 0, and neither the remap output nor the forward output is active.
- R2: An aligned dword write (length code 2, offset[1:0]=0) to an implemented slot stores (data AND NOT(size-1)) OR type. A dword read of that slot in a later cycle returns the stored value.
- R3: The following writes leave the bank unchanged and appear on the forward outputs one cycle later with offset, length and data unchanged: byte writes (code 0), halfword writes (code 1), misaligned dword writes, writes outside 0x10..0x27 and writes to unimplemented slots.
- R4: A dword write of 0xFFFFFFFF or 0x00000000 updates the stored value. It produces no remap event and does not change the command enables.
- R5: Any other dword write to an implemented slot raises remap_vld in the next cycle, with the slot index. The new base is the data with bits [1:0] cleared when type bit 0 is 1 (I/O), or with bits [3:0] cleared otherwise (memory).
- R6: On the first relocation of a slot since reset, remap_old_vld is 0 and remap_old_base is 0. On later relocations, remap_old_vld is 1 and remap_old_base equals the previous new base; probe writes in between do not change it.
- R7: Relocating an I/O slot sets cmd_io_en and relocating a memory slot sets cmd_mem_en. Both bits stay set until reset.
- R8: A read request is answered one cycle later with rd_vld. For an implemented slot, rd_hit is 1 and rd_data is the stored word shifted right by 8*offset[1:0], masked to 8 bits (code 0), 16 bits (code 1) or 32 bits (code 2 or 3). For any other offset, rd_hit and rd_data are 0.
- R9: A remap event lasts exactly one cycle per relocating write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_vld | input | 1 | Configuration write strobe |
| wr_off | input | 8 | Write byte offset |
| wr_len | input | 2 | Write length code: 0 byte, 1 half, 2 dword |
| wr_data | input | 32 | Write data |
| rd_req | input | 1 | Read request strobe |
| rd_off | input | 8 | Read byte offset |
| rd_len | input | 2 | Read length code |
| rd_vld | output | 1 | Read answer valid |
| rd_hit | output | 1 | Read served by the bank |
| rd_data | output | 32 | Read answer data |
| fwd_vld | output | 1 | Forwarded write to the generic store |
| fwd_off | output | 8 | Forwarded offset |
| fwd_len | output | 2 | Forwarded length code |
| fwd_data | output | 32 | Forwarded data |
| remap_vld | output | 1 | One-cycle relocation event |
| remap_idx | output | 3 | Relocated slot index |
| remap_old_base | output | 32 | Previous base, 0 if none |
| remap_old_vld | output | 1 | Previous base is meaningful |
| remap_new_base | output | 32 | New base |
| cmd_io_en | output | 1 | Command bit 0: I/O decoding enabled |
| cmd_mem_en | output | 1 | Command bit 1: memory decoding enabled |

## Verification
Every result is registered once. The forward fields, the remap event and the command enables all appear in the cycle after the clock edge that samples the write. A readback appears in the cycle after the edge that samples the request. The bench drives each stimulus on a falling edge, then samples on the next falling edge, half a cycle after the result's register has updated. One cycle later it samples again to confirm the remap strobe has dropped. Readbacks are issued only after the write's results have been checked, so a read never races the write it depends on.

// File: rtl/bar_pkg.sv
package bar_pkg;

    // length codes carried with every configuration access
    typedef enum logic [1:0] {
        LEN_BYTE  = 2'd0,
        LEN_HALF  = 2'd1,
        LEN_DWORD = 2'd2,
        LEN_RSVD  = 2'd3
    } acc_len_e;

    localparam int unsigned CFG_OFF_W = 8;
    localparam int unsigned CFG_DW    = 32;
    localparam int unsigned SLOT_MAX  = 6;
    localparam logic [CFG_OFF_W-1:0] WIN_BASE = 8'h10;

    // the two sizing values that do not move a region
    function automatic logic is_probe(input logic [CFG_DW-1:0] v);
        return (v == '1) || (v == '0);
    endfunction

endpackage

// File: rtl/bar_window_decode.sv
module bar_window_decode
    import bar_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 6,
    parameter int unsigned IDX_W     = 3
) (
    input  logic [CFG_OFF_W-1:0] off,
    output logic                 in_win,
    output logic [IDX_W-1:0]     idx,
    output logic [1:0]           lane
);
    localparam logic [CFG_OFF_W-1:0] WIN_BYTES = CFG_OFF_W'(4 * NUM_SLOTS);

    logic [CFG_OFF_W-1:0] rel;

    always_comb begin
        // below the window the subtraction wraps to a large value
        rel    = off - WIN_BASE;
        in_win = (rel < WIN_BYTES);
        idx    = rel[IDX_W+1:2];
        lane   = rel[1:0];
    end
endmodule

// File: rtl/bar_lane_extract.sv
module bar_lane_extract
    import bar_pkg::*;
(
    input  logic [CFG_DW-1:0] word,
    input  logic [1:0]        lane,
    input  logic [1:0]        len,
    output logic [CFG_DW-1:0] data
);
    logic [CFG_DW-1:0] shifted;

    always_comb begin
        shifted = word >> {lane, 3'b000};
        unique case (acc_len_e'(len))
            LEN_BYTE: data = shifted & CFG_DW'(32'h0000_00FF);
            LEN_HALF: data = shifted & CFG_DW'(32'h0000_FFFF);
            default:  data = shifted;
        endcase
    end
endmodule

// File: rtl/bar_slot.sv
module bar_slot
    import bar_pkg::*;
#(
    parameter int unsigned SIZE_LOG2 = 12,
    parameter logic [3:0]  TYPE_CODE = 4'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [CFG_DW-1:0] wdata,
    output logic [CFG_DW-1:0] enc_q,
    output logic [CFG_DW-1:0] base_q,
    output logic              mapped_q,
    output logic              reloc,
    output logic [CFG_DW-1:0] new_base
);
    localparam logic [CFG_DW-1:0] SIZE_MASK = ~((CFG_DW'(1) << SIZE_LOG2) - CFG_DW'(1));
    localparam bit                IS_IO     = TYPE_CODE[0];
    localparam int unsigned       BASE_LSB  = IS_IO ? 2 : 4;
    localparam logic [CFG_DW-1:0] BASE_MASK = ~((CFG_DW'(1) << BASE_LSB) - CFG_DW'(1));
    localparam logic [CFG_DW-1:0] TYPE_EXT  = CFG_DW'(TYPE_CODE);

    typedef struct packed {
        logic [CFG_DW-1:0] enc;
        logic [CFG_DW-1:0] base;
        logic              mapped;
    } slot_st_t;

    slot_st_t s_d, s_q;
    logic     probe;

    always_comb begin
        probe    = is_probe(wdata);
        reloc    = sel && !probe;
        new_base = wdata & BASE_MASK;
        s_d      = s_q;
        if (sel) begin
            s_d.enc = (wdata & SIZE_MASK) | TYPE_EXT;
            if (!probe) begin
                s_d.base   = new_base;
                s_d.mapped = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.enc    <= TYPE_EXT;
            s_q.base   <= '0;
            s_q.mapped <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign enc_q    = s_q.enc;
    assign base_q   = s_q.base;
    assign mapped_q = s_q.mapped;

    // R2
    enc_type_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.enc & ~SIZE_MASK) == TYPE_EXT);

    // R6
    mapped_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(s_q.mapped));

    // R5
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.mapped |-> ((s_q.base & ~BASE_MASK) == '0));

    // R4
    probe_keeps_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && probe) |=> $stable(s_q.base));
endmodule

// File: rtl/bar_bank.sv
module bar_bank
    import bar_pkg::*;
#(
    parameter int unsigned              NUM_SLOTS = 6,
    parameter logic [NUM_SLOTS*6-1:0]   SIZE_LOG2 = {6'd0, 6'd8, 6'd0, 6'd20, 6'd12, 6'd5},
    parameter logic [NUM_SLOTS*4-1:0]   TYPE_CODE = {4'h0, 4'h1, 4'h0, 4'h8, 4'h0, 4'h1},
    localparam int unsigned             IDX_W     = $clog2(SLOT_MAX),
    localparam int unsigned             PAD_SLOTS = 1 << IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_vld,
    input  logic [CFG_OFF_W-1:0] wr_off,
    input  logic [1:0]           wr_len,
    input  logic [CFG_DW-1:0]    wr_data,
    input  logic                 rd_req,
    input  logic [CFG_OFF_W-1:0] rd_off,
    input  logic [1:0]           rd_len,
    output logic                 rd_vld,
    output logic                 rd_hit,
    output logic [CFG_DW-1:0]    rd_data,
    output logic                 fwd_vld,
    output logic [CFG_OFF_W-1:0] fwd_off,
    output logic [1:0]           fwd_len,
    output logic [CFG_DW-1:0]    fwd_data,
    output logic                 remap_vld,
    output logic [IDX_W-1:0]     remap_idx,
    output logic [CFG_DW-1:0]    remap_old_base,
    output logic                 remap_old_vld,
    output logic [CFG_DW-1:0]    remap_new_base,
    output logic                 cmd_io_en,
    output logic                 cmd_mem_en
);
    typedef struct packed {
        logic                 fwd_vld;
        logic [CFG_OFF_W-1:0] fwd_off;
        logic [1:0]           fwd_len;
        logic [CFG_DW-1:0]    fwd_data;
        logic                 rm_vld;
        logic [IDX_W-1:0]     rm_idx;
        logic [CFG_DW-1:0]    rm_old;
        logic                 rm_old_vld;
        logic [CFG_DW-1:0]    rm_new;
        logic                 cmd_io;
        logic                 cmd_mem;
        logic                 rd_vld;
        logic                 rd_hit;
        logic [CFG_DW-1:0]    rd_data;
    } bank_st_t;

    bank_st_t st_d, st_q;

    // per-slot views padded to a power of two so any index is in range
    logic [PAD_SLOTS-1:0] impl_vec;
    logic [PAD_SLOTS-1:0] io_vec;
    logic [PAD_SLOTS-1:0] sel_vec;
    logic [PAD_SLOTS-1:0] reloc_vec;
    logic [PAD_SLOTS-1:0] mapped_vec;
    logic [CFG_DW-1:0]    enc_arr   [PAD_SLOTS];
    logic [CFG_DW-1:0]    base_arr  [PAD_SLOTS];
    logic [CFG_DW-1:0]    nbase_arr [PAD_SLOTS];

    logic             wr_in_win, rd_in_win;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [1:0]       wr_lane, rd_lane;
    logic             wr_take;
    logic             rd_take;
    logic [CFG_DW-1:0] rd_word;
    logic [CFG_DW-1:0] rd_lane_data;

    bar_window_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_wr_dec (
        .off(wr_off), .in_win(wr_in_win), .idx(wr_idx), .lane(wr_lane)
    );

    bar_window_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_rd_dec (
        .off(rd_off), .in_win(rd_in_win), .idx(rd_idx), .lane(rd_lane)
    );

    always_comb begin
        wr_take = wr_vld && wr_in_win && (wr_lane == 2'b00)
               && (acc_len_e'(wr_len) == LEN_DWORD) && impl_vec[wr_idx];
        for (int i = 0; i < PAD_SLOTS; i++) begin
            sel_vec[i] = wr_take && (wr_idx == IDX_W'(i));
        end
    end

    genvar g;
    generate
        for (g = 0; g < PAD_SLOTS; g++) begin : g_slot
            if (g < NUM_SLOTS && SIZE_LOG2[g*6 +: 6] != 6'd0) begin : g_impl
                bar_slot #(
                    .SIZE_LOG2(int'(SIZE_LOG2[g*6 +: 6])),
                    .TYPE_CODE(TYPE_CODE[g*4 +: 4])
                ) u_slot (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .sel     (sel_vec[g]),
                    .wdata   (wr_data),
                    .enc_q   (enc_arr[g]),
                    .base_q  (base_arr[g]),
                    .mapped_q(mapped_vec[g]),
                    .reloc   (reloc_vec[g]),
                    .new_base(nbase_arr[g])
                );
                assign impl_vec[g] = 1'b1;
                assign io_vec[g]   = TYPE_CODE[g*4];
            end else begin : g_absent
                assign enc_arr[g]    = '0;
                assign base_arr[g]   = '0;
                assign nbase_arr[g]  = '0;
                assign mapped_vec[g] = 1'b0;
                assign reloc_vec[g]  = 1'b0;
                assign impl_vec[g]   = 1'b0;
                assign io_vec[g]     = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rd_take = rd_in_win && impl_vec[rd_idx];
        rd_word = enc_arr[rd_idx];
    end

    bar_lane_extract u_lane (
        .word(rd_word), .lane(rd_lane), .len(rd_len), .data(rd_lane_data)
    );

    always_comb begin
        st_d = st_q;

        // forward path: everything the bank does not take
        st_d.fwd_vld  = wr_vld && !wr_take;
        st_d.fwd_off  = wr_off;
        st_d.fwd_len  = wr_len;
        st_d.fwd_data = wr_data;

        // remap event, one cycle per relocating write
        st_d.rm_vld     = |reloc_vec;
        st_d.rm_idx     = wr_idx;
        st_d.rm_new     = nbase_arr[wr_idx];
        st_d.rm_old_vld = mapped_vec[wr_idx];
        st_d.rm_old     = mapped_vec[wr_idx] ? base_arr[wr_idx] : '0;

        // command enables are sticky
        if (|reloc_vec) begin
            if (io_vec[wr_idx]) st_d.cmd_io  = 1'b1;
            else                st_d.cmd_mem = 1'b1;
        end

        // readback
        st_d.rd_vld  = rd_req;
        st_d.rd_hit  = rd_req && rd_take;
        st_d.rd_data = (rd_req && rd_take) ? rd_lane_data : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_vld        = st_q.fwd_vld;
    assign fwd_off        = st_q.fwd_off;
    assign fwd_len        = st_q.fwd_len;
    assign fwd_data       = st_q.fwd_data;
    assign remap_vld      = st_q.rm_vld;
    assign remap_idx      = st_q.rm_idx;
    assign remap_old_base = st_q.rm_old;
    assign remap_old_vld  = st_q.rm_old_vld;
    assign remap_new_base = st_q.rm_new;
    assign cmd_io_en      = st_q.cmd_io;
    assign cmd_mem_en     = st_q.cmd_mem;
    assign rd_vld         = st_q.rd_vld;
    assign rd_hit         = st_q.rd_hit;
    assign rd_data        = st_q.rd_data;

    // R5
    one_reloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reloc_vec));

    // R3
    fwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_vld |-> !fwd_vld);

    // R7
    cmd_follows_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_vld |-> (cmd_io_en || cmd_mem_en));

    // R7
    cmd_io_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cmd_io_en));

    // R7
    cmd_mem_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cmd_mem_en));

    // R9
    remap_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remap_vld |-> $past(wr_vld));

    // R8
    rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rd_data == '0));

    // R6
    old_invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remap_vld && !remap_old_vld) |-> (remap_old_base == '0));
endmodule

// File: tb/bar_bank_bench.sv
`timescale 1ns/1ps
module bar_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_vld = 1'b0;
    logic [7:0]  wr_off = '0;
    logic [1:0]  wr_len = '0;
    logic [31:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_off = '0;
    logic [1:0]  rd_len = '0;
    logic        rd_vld, rd_hit;
    logic [31:0] rd_data;
    logic        fwd_vld;
    logic [7:0]  fwd_off;
    logic [1:0]  fwd_len;
    logic [31:0] fwd_data;
    logic        remap_vld, remap_old_vld;
    logic [2:0]  remap_idx;
    logic [31:0] remap_old_base, remap_new_base;
    logic        cmd_io_en, cmd_mem_en;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    bar_bank u_bar_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_vld(wr_vld), .wr_off(wr_off), .wr_len(wr_len), .wr_data(wr_data),
        .rd_req(rd_req), .rd_off(rd_off), .rd_len(rd_len),
        .rd_vld(rd_vld), .rd_hit(rd_hit), .rd_data(rd_data),
        .fwd_vld(fwd_vld), .fwd_off(fwd_off), .fwd_len(fwd_len), .fwd_data(fwd_data),
        .remap_vld(remap_vld), .remap_idx(remap_idx),
        .remap_old_base(remap_old_base), .remap_old_vld(remap_old_vld),
        .remap_new_base(remap_new_base),
        .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en)
    );

    typedef struct packed {
        logic [7:0]  off;
        logic [1:0]  len;
        logic [31:0] data;
        logic        fwd;
        logic        rm;
        logic [2:0]  idx;
        logic [31:0] nbase;
        logic [31:0] obase;
        logic        ovld;
        logic [1:0]  cmd;   // {mem, io}
        logic        rhit;
        logic [31:0] rval;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{8'h10, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd0, 32'h0,         32'h0,         1'b0, 2'b00, 1'b1, 32'hFFFF_FFE1},
        '{8'h10, 2'd2, 32'h0000_C000, 1'b0, 1'b1, 3'd0, 32'h0000_C000, 32'h0,         1'b0, 2'b01, 1'b1, 32'h0000_C001},
        '{8'h10, 2'd2, 32'h0000_C043, 1'b0, 1'b1, 3'd0, 32'h0000_C040, 32'h0000_C000, 1'b1, 2'b01, 1'b1, 32'h0000_C041},
        '{8'h14, 2'd2, 32'hF000_0ABC, 1'b0, 1'b1, 3'd1, 32'hF000_0AB0, 32'h0,         1'b0, 2'b11, 1'b1, 32'hF000_0000},
        '{8'h18, 2'd2, 32'h0000_0000, 1'b0, 1'b0, 3'd0, 32'h0,         32'h0,         1'b0, 2'b11, 1'b1, 32'h0000_0008},
        '{8'h18, 2'd2, 32'hE001_2345, 1'b0, 1'b1, 3'd2, 32'hE001_2340, 32'h0,         1'b0, 2'b11, 1'b1, 32'hE000_0008},
        '{8'h1C, 2'd2, 32'h1234_5678, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,         1'b0, 2'b11, 1'b0, 32'h0},
        '{8'h20, 2'd2, 32'h0000_D0FF, 1'b0, 1'b1, 3'd4, 32'h0000_D0FC, 32'h0,         1'b0, 2'b11, 1'b1, 32'h0000_D001},
        '{8'h24, 2'd2, 32'hAAAA_AAAA, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,         1'b0, 2'b11, 1'b0, 32'h0},
        '{8'h04, 2'd2, 32'h0000_0007, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,         1'b0, 2'b11, 1'b0, 32'h0},
        '{8'h10, 2'd0, 32'h0000_0055, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,         1'b0, 2'b11, 1'b1, 32'h0000_C041},
        '{8'h12, 2'd1, 32'h0000_BEEF, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,         1'b0, 2'b11, 1'b1, 32'h0000_C041},
        '{8'h28, 2'd2, 32'h0000_0001, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,         1'b0, 2'b11, 1'b0, 32'h0},
        '{8'h11, 2'd2, 32'hFFFF_FFFF, 1'b1, 1'b0, 3'd0, 32'h0,         32'h0,         1'b0, 2'b11, 1'b1, 32'h0000_C041},
        '{8'h14, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, 3'd0, 32'h0,         32'h0,         1'b0, 2'b11, 1'b1, 32'hFFFF_F000},
        '{8'h14, 2'd2, 32'h8000_1000, 1'b0, 1'b1, 3'd1, 32'h8000_1000, 32'hF000_0AB0, 1'b1, 2'b11, 1'b1, 32'h8000_1000}
    };

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    // drive on a falling edge, the result is sampled on the following one
    task automatic do_write(input logic [7:0] off, input logic [1:0] len, input logic [31:0] d);
        @(negedge clk);
        wr_vld = 1'b1; wr_off = off; wr_len = len; wr_data = d;
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] off, input logic [1:0] len,
                           output logic hit, output logic [31:0] d);
        @(negedge clk);
        rd_req = 1'b1; rd_off = off; rd_len = len;
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_vld == 1'b1, "R8", "rd_vld", {31'd0, rd_vld}, 32'd1);
        hit = rd_hit;
        d   = rd_data;
    endtask

    task automatic expect_read(input logic [7:0] off, input logic [1:0] len,
                               input logic ehit, input logic [31:0] eval, input string req);
        logic h;
        logic [31:0] d;
        do_read(off, len, h, d);
        check(h == ehit, req, "rd_hit", {31'd0, h}, {31'd0, ehit});
        check(d == eval, req, "rd_data", d, eval);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        apply_reset();

        // R1: reset state
        @(negedge clk);
        check(remap_vld == 1'b0, "R1", "remap_vld", {31'd0, remap_vld}, 32'd0);
        check(fwd_vld == 1'b0,   "R1", "fwd_vld",   {31'd0, fwd_vld},   32'd0);
        check({cmd_mem_en, cmd_io_en} == 2'b00, "R1", "cmd", {30'd0, cmd_mem_en, cmd_io_en}, 32'd0);
        expect_read(8'h10, 2'd2, 1'b1, 32'h0000_0001, "R1");
        expect_read(8'h18, 2'd2, 1'b1, 32'h0000_0008, "R1");
        expect_read(8'h20, 2'd2, 1'b1, 32'h0000_0001, "R1");

        // table walk: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            do_write(v.off, v.len, v.data);
            check(fwd_vld == v.fwd, "R3", "fwd_vld", {31'd0, fwd_vld}, {31'd0, v.fwd});
            if (v.fwd) begin
                check(fwd_off == v.off,   "R3", "fwd_off",  {24'd0, fwd_off}, {24'd0, v.off});
                check(fwd_len == v.len,   "R3", "fwd_len",  {30'd0, fwd_len}, {30'd0, v.len});
                check(fwd_data == v.data, "R3", "fwd_data", fwd_data, v.data);
            end
            check(remap_vld == v.rm, "R4", "remap_vld", {31'd0, remap_vld}, {31'd0, v.rm});
            if (v.rm) begin
                check(remap_idx == v.idx,        "R5", "remap_idx", {29'd0, remap_idx}, {29'd0, v.idx});
                check(remap_new_base == v.nbase, "R5", "remap_new_base", remap_new_base, v.nbase);
                check(remap_old_vld == v.ovld,   "R6", "remap_old_vld", {31'd0, remap_old_vld}, {31'd0, v.ovld});
                check(remap_old_base == v.obase, "R6", "remap_old_base", remap_old_base, v.obase);
            end
            check({cmd_mem_en, cmd_io_en} == v.cmd, "R7", "cmd", {30'd0, cmd_mem_en, cmd_io_en}, {30'd0, v.cmd});
            @(negedge clk);
            check(remap_vld == 1'b0, "R9", "remap_vld after pulse", {31'd0, remap_vld}, 32'd0);
            expect_read(v.off & 8'hFC, 2'd2, v.rhit, v.rval, "R2");
        end

        // R8: byte lanes and lengths
        expect_read(8'h11, 2'd0, 1'b1, 32'h0000_00C0, "R8");
        expect_read(8'h12, 2'd1, 1'b1, 32'h0000_0000, "R8");
        expect_read(8'h16, 2'd1, 1'b1, 32'h0000_8000, "R8");
        expect_read(8'h1B, 2'd0, 1'b1, 32'h0000_00E0, "R8");
        expect_read(8'h20, 2'd3, 1'b1, 32'h0000_D001, "R8");
        expect_read(8'h1C, 2'd0, 1'b0, 32'h0000_0000, "R8");
        expect_read(8'h30, 2'd2, 1'b0, 32'h0000_0000, "R8");

        // R1 R6 R7: second reset clears mapping and enables
        apply_reset();
        @(negedge clk);
        check({cmd_mem_en, cmd_io_en} == 2'b00, "R1", "cmd after reset", {30'd0, cmd_mem_en, cmd_io_en}, 32'd0);
        expect_read(8'h14, 2'd2, 1'b1, 32'h0000_0000, "R1");
        do_write(8'h14, 2'd2, 32'h1000_0000);
        check(remap_vld == 1'b1,          "R5", "remap_vld", {31'd0, remap_vld}, 32'd1);
        check(remap_old_vld == 1'b0,      "R6", "old_vld after reset", {31'd0, remap_old_vld}, 32'd0);
        check(remap_old_base == 32'h0,    "R6", "old_base after reset", remap_old_base, 32'h0);
        check(remap_new_base == 32'h1000_0000, "R5", "new_base", remap_new_base, 32'h1000_0000);
        check({cmd_mem_en, cmd_io_en} == 2'b10, "R7", "cmd mem only", {30'd0, cmd_mem_en, cmd_io_en}, 32'd2);

        // R4: probe on an unmapped I/O slot keeps enables and raises no event
        do_write(8'h20, 2'd2, 32'hFFFF_FFFF);
        check(remap_vld == 1'b0, "R4", "probe remap", {31'd0, remap_vld}, 32'd0);
        check(cmd_io_en == 1'b0, "R4", "probe cmd_io", {31'd0, cmd_io_en}, 32'd0);
        expect_read(8'h20, 2'd2, 1'b1, 32'hFFFF_FF01, "R4");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule